// File: doc/BRIEF.md
# Dual-Output Programmable Interrupt Controller

This block gathers 51 interrupt request lines and turns them into two processor-facing outputs: a normal interrupt line and a fast interrupt line. Each source is sensed on its own terms. It can be level sensitive with either polarity, edge sensitive on a rising or a falling edge, or edge sensitive on any change of the input. Captured requests are kept in a raw status vector. A per-source enable gates each request, and a per-source routing bit sends it to one of the two outputs.

Software reaches the controller through a 32-bit, word-aligned register port. Each 51-bit logical register occupies two word addresses. The low word holds sources 0 to 31, and bits 0 to 18 of the high word hold sources 32 to 50. Enable bits and edge-captured requests are changed through dedicated set and clear addresses, so no read-modify-write is needed. The request inputs are taken to be synchronous to the register clock.

Top module: `intc_dual_out`

## Requirements
- R1: After a synchronous reset, the raw, routing and enable vectors and the stored previous input levels are all zero. The sensitivity vector (1 = level) reads 0x1F07FFF8FFFF, the both-edge vector reads 0xF800070000, and the polarity vector (1 = high/rising) reads 0x5F07FFF8FFFF.
- R2: The register window spans 0x80 to 0xE7. Address bit 2 selects the high word. A word-aligned address with bit 2 cleared selects the register: 0x80 normal-line status, 0x88 fast-line status, 0x90 raw, 0x98 routing, 0xA0 enable set, 0xA8 enable clear, 0xB0/0xB8 software set/clear, 0xC0 sensitivity, 0xC8 both-edge, 0xD0 polarity, 0xD8 edge clear, 0xE0 edge-captured status (raw with level sources masked). The high word returns source bits 32 to 50 in bits 0 to 18, with bits 19 to 31 reading zero.
- R3: Normal-line status is raw AND enable AND NOT routing. Fast-line status is raw AND enable AND routing. `irq_o` is high while any normal-line status bit is set, and `fiq_o` is high while any fast-line status bit is set. Both outputs are combinational from the stored state.
- R4: A level source follows its input one clock after the input is sampled. It is active-high when its polarity bit is 1 and active-low when its polarity bit is 0.
- R5: An edge source sets its raw bit one clock after the detecting edge, and the bit stays set until it is cleared. With the both-edge bit set, any change counts as an edge. Otherwise the polarity bit picks the edge: 1 for rising, 0 for falling. An edge is found by comparing the input with its value registered on the previous clock.
- R6: Writing ones to the enable set address sets the matching enable bits. Writing ones to the enable clear address clears them. Zero bits leave the enable bits unchanged.
- R7: Writing ones to the edge clear address clears the matching raw bits of edge sources only, and level sources are unaffected. If a new edge arrives in the same cycle as a clear, the new edge wins and the bit stays set.
- R8: A routing write replaces only the addressed half of the vector. A high-word write keeps only data bits 0 to 18.
- R9: The polarity register accepts only high-word writes, and only data bits 15 to 18 take effect (sources 47 to 50). Low-word writes and all other bits are ignored.
- R10: The following addresses read as zero: the enable clear, edge clear and software set/clear addresses, any unmapped or non-aligned address, and anything below 0x80. Writes to the status, raw, sensitivity, both-edge, edge-status, software and unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 51 | Interrupt request inputs, one per source |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
Three timings govern the checks. Read data depends combinationally on `bus_addr`. A write becomes visible at the first rising edge after the strobe. A request input changes the raw vector, and through it both outputs, at the first rising edge after the input is sampled. The bench therefore drives stimulus on a falling edge and lets exactly one rising edge pass. It then samples on the next falling edge, with a short settle delay for reads. The same-cycle case, where an edge clear and a new edge arrive together, is driven on a single falling edge so that both are seen at the same rising edge.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NUM_SRC = 51;
    localparam int WORD_W  = 32;
    localparam int HI_W    = NUM_SRC - WORD_W;
    localparam int ADDR_W  = 8;
    localparam int POL_LO  = 47;
    localparam int POL_N   = 4;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [WORD_W-1:0]  word_t;

    localparam src_vec_t SENSE_RST = 51'h1F07FFF8FFFF;
    localparam src_vec_t DUAL_RST  = 51'h00F800070000;
    localparam src_vec_t POL_RST   = 51'h5F07FFF8FFFF;
    localparam src_vec_t POL_WMASK = src_vec_t'({POL_N{1'b1}}) << POL_LO;

    // register selector = address bits [7:3]
    typedef enum logic [4:0] {
        SEL_NONE    = 5'h00,
        SEL_IRQ_ST  = 5'h10,
        SEL_FIQ_ST  = 5'h11,
        SEL_RAW     = 5'h12,
        SEL_ROUTE   = 5'h13,
        SEL_EN_SET  = 5'h14,
        SEL_EN_CLR  = 5'h15,
        SEL_SW_SET  = 5'h16,
        SEL_SW_CLR  = 5'h17,
        SEL_SENSE   = 5'h18,
        SEL_DUAL    = 5'h19,
        SEL_POL     = 5'h1A,
        SEL_EDGE_CL = 5'h1B,
        SEL_EDGE_ST = 5'h1C
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     hi;
        reg_sel_e sel;
        word_t    data;
    } bus_req_t;

    typedef struct packed {
        src_vec_t route;
        src_vec_t enable;
        src_vec_t pol;
    } cfg_t;

    function automatic bus_req_t decode_req(input logic wr, input logic [ADDR_W-1:0] addr,
                                            input word_t data);
        bus_req_t r;
        r.wr   = wr;
        r.hi   = addr[2];
        r.data = data;
        if (addr[7] && addr[1:0] == 2'b00)
            r.sel = reg_sel_e'(addr[7:3]);
        else
            r.sel = SEL_NONE;
        return r;
    endfunction

    function automatic src_vec_t place_word(input logic hi, input word_t d);
        if (hi)
            return {d[HI_W-1:0], {WORD_W{1'b0}}};
        return {{HI_W{1'b0}}, d};
    endfunction

    function automatic word_t pick_word(input logic hi, input src_vec_t v);
        if (hi)
            return {{(WORD_W-HI_W){1'b0}}, v[NUM_SRC-1:WORD_W]};
        return v[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/intc_capture.sv
module intc_capture
    import intc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t src_i,
    input  src_vec_t sense_i,
    input  src_vec_t dual_i,
    input  src_vec_t pol_i,
    input  src_vec_t clr_i,
    output src_vec_t raw_o
);

    src_vec_t prev_q;
    src_vec_t raw_q;
    src_vec_t raw_d;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic hit;
        logic lvl;
        always_comb begin
            if (dual_i[i])
                hit = src_i[i] ^ prev_q[i];
            else if (pol_i[i])
                hit = src_i[i] & ~prev_q[i];
            else
                hit = ~src_i[i] & prev_q[i];
            lvl = ~(src_i[i] ^ pol_i[i]);
        end
        // a fresh edge overrides a clear in the same cycle
        assign raw_d[i] = sense_i[i] ? lvl : (hit | (raw_q[i] & ~clr_i[i]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            raw_q  <= '0;
        end else begin
            prev_q <= src_i;
            raw_q  <= raw_d;
        end
    end

    assign raw_o = raw_q;

endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req_i,
    input  src_vec_t raw_i,
    input  src_vec_t irq_st_i,
    input  src_vec_t fiq_st_i,
    output cfg_t     cfg_o,
    output src_vec_t edge_clr_o,
    output word_t    rdata_o
);

    cfg_t     cfg_q;
    src_vec_t wvec;
    src_vec_t rvec;

    assign wvec = place_word(req_i.hi, req_i.data);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.route  <= '0;
            cfg_q.enable <= '0;
            cfg_q.pol    <= POL_RST;
        end else if (req_i.wr) begin
            case (req_i.sel)
                SEL_ROUTE: begin
                    if (req_i.hi)
                        cfg_q.route[NUM_SRC-1:WORD_W] <= wvec[NUM_SRC-1:WORD_W];
                    else
                        cfg_q.route[WORD_W-1:0] <= wvec[WORD_W-1:0];
                end
                SEL_EN_SET: cfg_q.enable <= cfg_q.enable | wvec;
                SEL_EN_CLR: cfg_q.enable <= cfg_q.enable & ~wvec;
                SEL_POL: begin
                    if (req_i.hi)
                        cfg_q.pol <= (cfg_q.pol & ~POL_WMASK) | (wvec & POL_WMASK);
                end
                default: ;
            endcase
        end
    end

    assign edge_clr_o = (req_i.wr && req_i.sel == SEL_EDGE_CL) ? (wvec & ~SENSE_RST) : '0;

    always_comb begin
        case (req_i.sel)
            SEL_IRQ_ST:  rvec = irq_st_i;
            SEL_FIQ_ST:  rvec = fiq_st_i;
            SEL_RAW:     rvec = raw_i;
            SEL_ROUTE:   rvec = cfg_q.route;
            SEL_EN_SET:  rvec = cfg_q.enable;
            SEL_SENSE:   rvec = SENSE_RST;
            SEL_DUAL:    rvec = DUAL_RST;
            SEL_POL:     rvec = cfg_q.pol;
            SEL_EDGE_ST: rvec = raw_i & ~SENSE_RST;
            default:     rvec = '0;
        endcase
    end

    assign rdata_o = pick_word(req_i.hi, rvec);
    assign cfg_o   = cfg_q;

endmodule

// File: rtl/intc_dual_out.sv
module intc_dual_out
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);

    bus_req_t req;
    cfg_t     cfg;
    src_vec_t raw_vec;
    src_vec_t edge_clr;
    src_vec_t irq_st;
    src_vec_t fiq_st;
    src_vec_t en_vec;
    src_vec_t route_vec;
    src_vec_t pol_vec;

    assign req       = decode_req(bus_wr, bus_addr, bus_wdata);
    assign en_vec    = cfg.enable;
    assign route_vec = cfg.route;
    assign pol_vec   = cfg.pol;

    assign irq_st = raw_vec & en_vec & ~route_vec;
    assign fiq_st = raw_vec & en_vec & route_vec;
    assign irq_o  = |irq_st;
    assign fiq_o  = |fiq_st;

    intc_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .src_i   (src_i),
        .sense_i (SENSE_RST),
        .dual_i  (DUAL_RST),
        .pol_i   (pol_vec),
        .clr_i   (edge_clr),
        .raw_o   (raw_vec)
    );

    intc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .raw_i      (raw_vec),
        .irq_st_i   (irq_st),
        .fiq_st_i   (fiq_st),
        .cfg_o      (cfg),
        .edge_clr_o (edge_clr),
        .rdata_o    (bus_rdata)
    );

endmodule

// File: rtl/intc_dual_out_chk.sv
module intc_dual_out_chk
    import intc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NUM_SRC-1:0] src_i,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              irq_o,
    input logic              fiq_o,
    input src_vec_t          raw_vec,
    input src_vec_t          en_vec,
    input src_vec_t          route_vec,
    input src_vec_t          pol_vec,
    input src_vec_t          edge_clr
);

    logic valid_q;
    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= 1'b1;
    end

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> ((raw_vec & SENSE_RST) == $past((src_i ~^ pol_vec) & SENSE_RST))); // R4

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (($past(raw_vec) & ~$past(edge_clr) & ~SENSE_RST & ~raw_vec) == '0)); // R5

    AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
        (en_vec == '0) |-> (!irq_o && !fiq_o)); // R3

    AST_ENABLE_SET: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'hA0) |=> ((en_vec[WORD_W-1:0] & $past(bus_wdata)) == $past(bus_wdata))); // R6

    AST_ROUTE_HALF: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h98) |=> $stable(route_vec[NUM_SRC-1:WORD_W])); // R8

    AST_POL_FIXED: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (pol_vec[POL_LO-1:0] == POL_RST[POL_LO-1:0])); // R9

endmodule

bind intc_dual_out intc_dual_out_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_i),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .raw_vec   (raw_vec),
    .en_vec    (en_vec),
    .route_vec (route_vec),
    .pol_vec   (pol_vec),
    .edge_clr  (edge_clr)
);

// File: tb/intc_dual_out_bench.sv
`timescale 1ns/1ps
module intc_dual_out_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [50:0] src = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        fiq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    intc_dual_out u_intc_dual_out (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'hC0, 32'h0, 32'hFFF8FFFF, 4'd1},  // R1 sensitivity low
        '{1'b0, 8'hC4, 32'h0, 32'h00001F07, 4'd1},  // R1 sensitivity high
        '{1'b0, 8'hC8, 32'h0, 32'h00070000, 4'd1},  // R1 both-edge low
        '{1'b0, 8'hCC, 32'h0, 32'h000000F8, 4'd1},  // R1 both-edge high
        '{1'b0, 8'hD0, 32'h0, 32'hFFF8FFFF, 4'd1},  // R1 polarity low
        '{1'b0, 8'hD4, 32'h0, 32'h00005F07, 4'd1},  // R1 polarity high
        '{1'b0, 8'hA0, 32'h0, 32'h00000000, 4'd1},  // R1 enable
        '{1'b1, 8'h98, 32'hA5A50F0F, 32'h0, 4'd8},
        '{1'b1, 8'h9C, 32'hFFFFFFFF, 32'h0, 4'd8},
        '{1'b0, 8'h98, 32'h0, 32'hA5A50F0F, 4'd8},  // R8
        '{1'b0, 8'h9C, 32'h0, 32'h0007FFFF, 4'd8},  // R8 masked to 19 bits
        '{1'b1, 8'h98, 32'h12345678, 32'h0, 4'd8},
        '{1'b0, 8'h9C, 32'h0, 32'h0007FFFF, 4'd8},  // R8 high half kept
        '{1'b0, 8'h98, 32'h0, 32'h12345678, 4'd8},  // R8
        '{1'b1, 8'hA0, 32'h000000F0, 32'h0, 4'd6},
        '{1'b1, 8'hA0, 32'h0000000F, 32'h0, 4'd6},
        '{1'b0, 8'hA0, 32'h0, 32'h000000FF, 4'd6},  // R6 set accumulates
        '{1'b1, 8'hA8, 32'h0000003C, 32'h0, 4'd6},
        '{1'b0, 8'hA0, 32'h0, 32'h000000C3, 4'd6},  // R6 clear
        '{1'b0, 8'hA8, 32'h0, 32'h00000000, 4'd10}, // R10 write-only
        '{1'b1, 8'hA4, 32'h00040001, 32'h0, 4'd2},
        '{1'b0, 8'hA4, 32'h0, 32'h00040001, 4'd2},  // R2 high word
        '{1'b1, 8'hD0, 32'h00000000, 32'h0, 4'd9},
        '{1'b0, 8'hD0, 32'h0, 32'hFFF8FFFF, 4'd9},  // R9 low write ignored
        '{1'b1, 8'hD4, 32'hFFFFFFFF, 32'h0, 4'd9},
        '{1'b0, 8'hD4, 32'h0, 32'h0007DF07, 4'd9},  // R9 only 47..50
        '{1'b1, 8'hD4, 32'h00000000, 32'h0, 4'd9},
        '{1'b0, 8'hD4, 32'h0, 32'h00005F07, 4'd9},  // R9
        '{1'b1, 8'hC8, 32'hFFFFFFFF, 32'h0, 4'd10},
        '{1'b0, 8'hC8, 32'h0, 32'h00070000, 4'd10}, // R10 read-only
        '{1'b1, 8'hB0, 32'hFFFFFFFF, 32'h0, 4'd10},
        '{1'b0, 8'hB0, 32'h0, 32'h00000000, 4'd10}, // R10 software set
        '{1'b0, 8'h40, 32'h0, 32'h00000000, 4'd10}  // R10 below window
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic drive(input int idx, input logic v);
        @(negedge clk);
        src[idx] = v;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
            else rd($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].addr, VEC[i].exp);
        end
        rd("R10 unmapped", 8'hF0, 32'h0);

        // reset state
        do_reset();
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 fiq", {31'b0, fiq_o}, 32'h0);
        rd("R1 raw", 8'h90, 32'h0);
        rd("R1 route", 8'h98, 32'h0);

        // level source 0, normal line
        wr(8'hA0, 32'h1);
        drive(0, 1'b1);
        check("R4 irq on level", {31'b0, irq_o}, 32'h1);
        check("R3 fiq idle", {31'b0, fiq_o}, 32'h0);
        rd("R3 irq status", 8'h80, 32'h1);
        rd("R3 fiq status", 8'h88, 32'h0);
        drive(0, 1'b0);
        check("R4 level drop", {31'b0, irq_o}, 32'h0);
        rd("R4 raw clear", 8'h90, 32'h0);

        // route to fast line
        wr(8'h98, 32'h1);
        drive(0, 1'b1);
        check("R3 fiq routed", {31'b0, fiq_o}, 32'h1);
        check("R3 irq masked", {31'b0, irq_o}, 32'h0);
        rd("R3 fiq status", 8'h88, 32'h1);
        wr(8'hA8, 32'h1);
        check("R6 disable gates", {31'b0, fiq_o}, 32'h0);
        rd("R3 raw kept", 8'h90, 32'h1);
        drive(0, 1'b0);
        wr(8'h98, 32'h0);

        // rising edge on source 47
        wr(8'hD4, 32'h00008000);
        wr(8'hA4, 32'h00008000);
        drive(47, 1'b1);
        rd("R5 rising", 8'h94, 32'h00008000);
        check("R5 irq edge", {31'b0, irq_o}, 32'h1);
        drive(47, 1'b0);
        rd("R5 sticky", 8'h94, 32'h00008000);
        rd("R2 edge status hi", 8'hE4, 32'h00008000);
        wr(8'hDC, 32'h00008000);
        rd("R7 edge cleared", 8'h94, 32'h0);
        check("R7 irq off", {31'b0, irq_o}, 32'h0);

        // falling edge on source 48
        drive(48, 1'b1);
        rd("R5 no rise", 8'h94, 32'h0);
        drive(48, 1'b0);
        rd("R5 falling", 8'h94, 32'h00010000);
        wr(8'hDC, 32'h00010000);
        rd("R7 clear 48", 8'h94, 32'h0);

        // both edges on source 16
        drive(16, 1'b1);
        rd("R5 both rise", 8'h90, 32'h00010000);
        wr(8'hD8, 32'h00010000);
        rd("R7 clear 16", 8'h90, 32'h0);
        drive(16, 1'b0);
        rd("R5 both fall", 8'h90, 32'h00010000);
        wr(8'hD8, 32'h00010000);

        // edge clear ignores level source 1
        drive(1, 1'b1);
        rd("R4 level 1", 8'h90, 32'h00000002);
        wr(8'hD8, 32'h00000002);
        rd("R7 level untouched", 8'h90, 32'h00000002);
        rd("R2 edge status lo", 8'hE0, 32'h0);
        rd("R10 edge clear reads 0", 8'hD8, 32'h0);
        drive(1, 1'b0);
        rd("R4 level 1 off", 8'h90, 32'h0);

        // clear and new edge in the same cycle on source 17
        @(negedge clk);
        src[17] = 1'b1;
        bus_wr = 1'b1; bus_addr = 8'hD8; bus_wdata = 32'h00020000;
        @(negedge clk);
        bus_wr = 1'b0;
        rd("R7 edge wins", 8'h90, 32'h00020000);
        wr(8'hD8, 32'h00020000);
        rd("R7 later clear", 8'h90, 32'h0);

        // write to raw ignored
        drive(1, 1'b1);
        wr(8'h90, 32'h0);
        rd("R10 raw write ignored", 8'h90, 32'h00000002);
        rd("R10 misaligned", 8'h91, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule